// File: doc/BRIEF.md
# Outer-Product Accumulator Register Engine

This block is a compute engine that sits beside a host and is driven through a command port. It holds three banks of 64-byte lines: an operand bank X of eight columns, an operand bank Y of eight rows, and an accumulator bank Z of sixty-four columns. Commands switch the engine on or off, move whole lines between the data port and any line of any bank, and run an outer-product-accumulate step. That step multiplies one X column by one Y row, element by element, and adds the full product matrix into Z.

The accumulator bank is interleaved by lane width. With 32-bit lanes each line carries sixteen elements, and product column j lands in Z column `zoff + 4*j`. With 64-bit lanes each line carries eight elements, and product column j lands in Z column `zoff + 8*j`. The X column, the Y row and the Z offset are each chosen by the command. All lanes use two's-complement integer arithmetic that wraps at the lane width. One command is accepted in every cycle, and a compute step can issue in every cycle.

Top module: `opa_engine`

## Requirements
- R1: While reset is held low at a clock edge, `active`, `err` and `rsp_valid` are 0, `cmd_ready` is 1, and every line of X, Y and Z reads back as zero once the engine is started.
- R2: Opcode 0 (start) sets `active` to 1 on the accepting edge. Opcode 1 (stop) clears `active` and zeroes every line of X, Y and Z.
- R3: While `active` is 0, any command other than start changes no register, returns no response and sets `err`. `err` stays set until reset.
- R4: Opcode 2 (load) writes `cmd_data` into the line picked by `cmd_bank` (0 = X, 1 = Y, 2 = Z) and `cmd_idx`. X and Y use the low three bits of `cmd_idx`. Opcode 3 (store) puts that line on `rsp_data`, with `rsp_valid` high for exactly the one cycle after the accepting edge.
- R5: Opcode 4 with `cmd_wide`=0 splits each line into sixteen 32-bit elements, element i at bits [32i+31:32i]. For each j it adds X[xsel] element i times Y[ysel] element j, modulo 2^32, into element i of Z column (zoff mod 4) + 4j.
- R6: Opcode 4 with `cmd_wide`=1 splits each line into eight 64-bit elements, element i at bits [64i+63:64i]. For each j it adds the product, modulo 2^64, into element i of Z column zoff + 8j.
- R7: A compute step leaves X, Y and every Z column outside its target set unchanged.
- R8: Commands are accepted in back-to-back cycles. Each compute step sees every load and every compute step accepted in an earlier cycle, including one accepted in the cycle just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 3 | Opcode: 0 start, 1 stop, 2 load, 3 store, 4 compute |
| cmd_bank | input | 2 | Bank for load/store: 0 X, 1 Y, 2 Z |
| cmd_idx | input | 6 | Line index within the bank |
| cmd_wide | input | 1 | Compute lane width: 0 = 32-bit, 1 = 64-bit |
| cmd_xsel | input | 3 | X column for compute |
| cmd_ysel | input | 3 | Y row for compute |
| cmd_zoff | input | 3 | Z column offset for compute |
| cmd_data | input | 512 | Line written by load |
| rsp_valid | output | 1 | Store response present |
| rsp_data | output | 512 | Line returned by store |
| active | output | 1 | Engine enabled |
| err | output | 1 | Sticky flag: command issued while disabled |

## Verification
Loads, compute steps, start and stop all take effect on the edge that accepts them, so the state they change can be read one cycle later. A store answers on the edge that accepts it, so the bench drives each command at a falling edge and samples `rsp_data` and `rsp_valid` at the next falling edge, then checks that `rsp_valid` drops one cycle after that. `err` and `active` are sampled at the first falling edge after the accepting edge. Compute steps are issued in unbroken runs of cycles, and the accumulator is read back only after the run ends and is compared with the bench's arithmetic model.

// File: rtl/opa_pkg.sv
// Shared encodings for the outer-product accumulator engine.
// Assumes a 3-bit opcode field and a 2-bit bank field on the command port.
package opa_pkg;
    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_STOP  = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_MAC   = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        BANK_X = 2'd0,
        BANK_Y = 2'd1,
        BANK_Z = 2'd2
    } bank_e;
endpackage

// File: rtl/opa_line_file.sv
// Line register file used for the X and Y operand banks.
// One write port and a clear that zeroes every line; all lines are visible at
// once. Assumes clr_i and we_i are never both needed in one cycle (clear wins).
module opa_line_file #(
    parameter int LINE_W = 512,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [LINE_W-1:0] wdata_i,
    output logic [LINE_W-1:0] lines_o [DEPTH]
);
    // Hold the lines: reset or clear zeroes all, a write updates one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int k = 0; k < DEPTH; k++) lines_o[k] <= '0;
        end else if (we_i) begin
            lines_o[widx_i] <= wdata_i;
        end
    end

    // R2: a clear leaves the bank at zero on the next cycle
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (lines_o[0] == '0 && lines_o[DEPTH-1] == '0));
endmodule

// File: rtl/opa_lane_mac.sv
// Multiply-accumulate over one accumulator line.
// Adds x_i times a single scalar into acc_i, element by element, as sixteen
// 32-bit lanes or eight 64-bit lanes. Sums wrap at the lane width.
module opa_lane_mac #(
    parameter int LINE_W = 512,
    localparam int NL    = LINE_W / 32,
    localparam int WL    = LINE_W / 64
) (
    input  logic [LINE_W-1:0] acc_i,
    input  logic [LINE_W-1:0] x_i,
    input  logic [31:0]       y_nar_i,
    input  logic [63:0]       y_wid_i,
    input  logic              wide_i,
    output logic [LINE_W-1:0] sum_o
);
    logic [LINE_W-1:0] nsum;
    logic [LINE_W-1:0] wsum;

    for (genvar i = 0; i < NL; i++) begin : g_nar
        // Narrow lane i: 32-bit wrap-around multiply-add.
        assign nsum[32*i +: 32] = acc_i[32*i +: 32] + x_i[32*i +: 32] * y_nar_i;
    end

    for (genvar i = 0; i < WL; i++) begin : g_wid
        // Wide lane i: 64-bit wrap-around multiply-add.
        assign wsum[64*i +: 64] = acc_i[64*i +: 64] + x_i[64*i +: 64] * y_wid_i;
    end

    // Pick the lane layout for this step.
    assign sum_o = wide_i ? wsum : nsum;
endmodule

// File: rtl/opa_accum_plane.sv
// Outer-product plane: for every product column j it picks the interleaved Z
// column, reads it, and computes the updated line. Slots past the wide lane
// count are unused in 64-bit mode. Assumes Z_DEPTH is a multiple of the
// narrow lane count.
module opa_accum_plane #(
    parameter int LINE_W  = 512,
    parameter int Z_DEPTH = 64,
    localparam int SLOTS  = LINE_W / 32,
    localparam int WLANES = LINE_W / 64,
    localparam int NSTR   = Z_DEPTH / SLOTS,
    localparam int WSTR   = Z_DEPTH / WLANES,
    localparam int ZIDX_W = $clog2(Z_DEPTH),
    localparam int ZOFF_W = $clog2(WSTR)
) (
    input  logic [LINE_W-1:0] z_i [Z_DEPTH],
    input  logic [LINE_W-1:0] x_i,
    input  logic [LINE_W-1:0] y_i,
    input  logic              wide_i,
    input  logic [ZOFF_W-1:0] zoff_i,
    output logic [ZIDX_W-1:0] col_o [SLOTS],
    output logic [SLOTS-1:0]  use_o,
    output logic [LINE_W-1:0] sum_o [SLOTS]
);
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        logic [ZIDX_W-1:0] ncol;
        logic [ZIDX_W-1:0] wcol;
        logic [63:0]       y_wid;

        // Target column in each mode: offset plus stride times slot number.
        assign ncol = ZIDX_W'(j * NSTR + (int'(zoff_i) % NSTR));
        assign wcol = ZIDX_W'(j * WSTR + int'(zoff_i));
        assign col_o[j] = wide_i ? wcol : ncol;

        if (j < WLANES) begin : g_both
            // Slot carries a product column in either mode.
            assign y_wid    = y_i[64*j +: 64];
            assign use_o[j] = 1'b1;
        end else begin : g_nar_only
            // Slot only exists with 32-bit lanes.
            assign y_wid    = '0;
            assign use_o[j] = !wide_i;
        end

        opa_lane_mac #(.LINE_W(LINE_W)) u_mac (
            .acc_i   (z_i[col_o[j]]),
            .x_i     (x_i),
            .y_nar_i (y_i[32*j +: 32]),
            .y_wid_i (y_wid),
            .wide_i  (wide_i),
            .sum_o   (sum_o[j])
        );
    end
endmodule

// File: rtl/opa_engine.sv
// Outer-product accumulator engine, top level.
// Takes one command per cycle (cmd_ready is always high). Loads, compute steps,
// start and stop take effect on the accepting edge; a store answers one cycle
// later on rsp_*. Commands other than start are dropped while the engine is
// disabled and raise the sticky err flag. Stop zeroes every bank.
module opa_engine #(
    parameter int LINE_BYTES = 64,
    parameter int X_COLS     = 8,
    parameter int Y_ROWS     = 8,
    parameter int Z_COLS     = 64
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cmd_valid,
    output logic                                       cmd_ready,
    input  logic [2:0]                                 cmd_op,
    input  logic [1:0]                                 cmd_bank,
    input  logic [$clog2(Z_COLS)-1:0]                  cmd_idx,
    input  logic                                       cmd_wide,
    input  logic [$clog2(X_COLS)-1:0]                  cmd_xsel,
    input  logic [$clog2(Y_ROWS)-1:0]                  cmd_ysel,
    input  logic [$clog2(Z_COLS/(LINE_BYTES/8))-1:0]   cmd_zoff,
    input  logic [LINE_BYTES*8-1:0]                    cmd_data,
    output logic                                       rsp_valid,
    output logic [LINE_BYTES*8-1:0]                    rsp_data,
    output logic                                       active,
    output logic                                       err
);
    import opa_pkg::*;

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int SLOTS  = LINE_W / 32;
    localparam int ZIDX_W = $clog2(Z_COLS);
    localparam int XIDX_W = $clog2(X_COLS);
    localparam int YIDX_W = $clog2(Y_ROWS);

    logic              take;
    logic              go;
    logic              do_stop;
    logic              do_load;
    logic              do_store;
    logic              do_mac;
    logic [LINE_W-1:0] x_lines [X_COLS];
    logic [LINE_W-1:0] y_lines [Y_ROWS];
    logic [LINE_W-1:0] z_lines [Z_COLS];
    logic [ZIDX_W-1:0] slot_col [SLOTS];
    logic [SLOTS-1:0]  slot_use;
    logic [LINE_W-1:0] slot_sum [SLOTS];
    logic [LINE_W-1:0] rd_line;

    // Command decode: every command is taken; only an enabled engine acts.
    assign cmd_ready = 1'b1;
    assign take      = cmd_valid && cmd_ready;
    assign go        = take && active;
    assign do_stop   = go && (cmd_op == OP_STOP);
    assign do_load   = go && (cmd_op == OP_LOAD);
    assign do_store  = go && (cmd_op == OP_STORE);
    assign do_mac    = go && (cmd_op == OP_MAC);

    // Enable state: start sets it, an accepted stop clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          active <= 1'b0;
        else if (take && cmd_op == OP_START) active <= 1'b1;
        else if (do_stop)                    active <= 1'b0;
    end

    // Sticky error on any non-start command while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     err <= 1'b0;
        else if (take && !active && cmd_op != OP_START) err <= 1'b1;
    end

    opa_line_file #(.LINE_W(LINE_W), .DEPTH(X_COLS)) u_xbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (do_stop),
        .we_i    (do_load && cmd_bank == BANK_X),
        .widx_i  (cmd_idx[XIDX_W-1:0]),
        .wdata_i (cmd_data),
        .lines_o (x_lines)
    );

    opa_line_file #(.LINE_W(LINE_W), .DEPTH(Y_ROWS)) u_ybank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (do_stop),
        .we_i    (do_load && cmd_bank == BANK_Y),
        .widx_i  (cmd_idx[YIDX_W-1:0]),
        .wdata_i (cmd_data),
        .lines_o (y_lines)
    );

    opa_accum_plane #(.LINE_W(LINE_W), .Z_DEPTH(Z_COLS)) u_plane (
        .z_i    (z_lines),
        .x_i    (x_lines[cmd_xsel]),
        .y_i    (y_lines[cmd_ysel]),
        .wide_i (cmd_wide),
        .zoff_i (cmd_zoff),
        .col_o  (slot_col),
        .use_o  (slot_use),
        .sum_o  (slot_sum)
    );

    // Accumulator bank: clear, single-line load, or scatter of slot results.
    always_ff @(posedge clk) begin
        if (!rst_n || do_stop) begin
            for (int k = 0; k < Z_COLS; k++) z_lines[k] <= '0;
        end else if (do_load && cmd_bank == BANK_Z) begin
            z_lines[cmd_idx] <= cmd_data;
        end else if (do_mac) begin
            for (int j = 0; j < SLOTS; j++)
                if (slot_use[j]) z_lines[slot_col[j]] <= slot_sum[j];
        end
    end

    // Store source select by bank; an unused bank code reads zero.
    always_comb begin
        case (cmd_bank)
            BANK_X:  rd_line = x_lines[cmd_idx[XIDX_W-1:0]];
            BANK_Y:  rd_line = y_lines[cmd_idx[YIDX_W-1:0]];
            BANK_Z:  rd_line = z_lines[cmd_idx];
            default: rd_line = '0;
        endcase
    end

    // Store response register: valid for the one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= do_store;
            if (do_store) rsp_data <= rd_line;
        end
    end

    // R2: start enables the engine
    a_r2_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_START) |=> active);

    // R2: stop returns the engine to idle
    a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && active && cmd_op == OP_STOP) |=> !active);

    // R3: a command while disabled raises the flag
    a_r3_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !active && cmd_op != OP_START) |=> err);

    // R3: the flag never clears outside reset
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R3: a command while disabled leaves the enable state alone
    a_r3_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !active && cmd_op != OP_START) |=> !active);

    // R4: an accepted store answers on the next cycle
    a_r4_rsp_due: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && active && cmd_op == OP_STORE) |=> rsp_valid);

    // R4: no response without an accepted store one cycle earlier
    a_r4_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid && active && cmd_op == OP_STORE));

    // R6: in 64-bit mode only the wide-lane slots write
    a_r6_wide_slots: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wide |-> ($countones(slot_use) == LINE_W / 64));
endmodule

// File: tb/opa_engine_bench.sv
// Self-checking bench for opa_engine: sweeps the X/Y/Z selections in both
// lane modes and compares every accumulator line with an arithmetic model.
module opa_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [1:0]    cmd_bank = '0;
    logic [5:0]    cmd_idx = '0;
    logic          cmd_wide = 1'b0;
    logic [2:0]    cmd_xsel = '0;
    logic [2:0]    cmd_ysel = '0;
    logic [2:0]    cmd_zoff = '0;
    logic [LW-1:0] cmd_data = '0;
    logic          rsp_valid;
    logic [LW-1:0] rsp_data;
    logic          active;
    logic          err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    logic [LW-1:0] xm [8];
    logic [LW-1:0] ym [8];
    logic [LW-1:0] zm [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    opa_engine u_opa_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_idx(cmd_idx),
        .cmd_wide(cmd_wide), .cmd_xsel(cmd_xsel), .cmd_ysel(cmd_ysel),
        .cmd_zoff(cmd_zoff), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .active(active), .err(err)
    );

    function automatic logic [LW-1:0] next_line();
        logic [LW-1:0] v;
        for (int k = 0; k < LW / 32; k++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            v[32*k +: 32] = seed;
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Drive one command; it is accepted on the following rising edge.
    task automatic issue(input logic [2:0] op, input logic [1:0] bank, input int idx,
                         input logic [LW-1:0] data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_bank  = bank;
        cmd_idx   = 6'(idx);
        cmd_data  = data;
        @(posedge clk);
    endtask

    task automatic load(input logic [1:0] bank, input int idx, input logic [LW-1:0] data);
        issue(3'd2, bank, idx, data);
        if (bank == 2'd0) xm[idx % 8] = data;
        else if (bank == 2'd1) ym[idx % 8] = data;
        else zm[idx] = data;
    endtask

    task automatic mac(input bit wide, input int xs, input int ys, input int zo);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'd4;
        cmd_wide  = wide;
        cmd_xsel  = 3'(xs);
        cmd_ysel  = 3'(ys);
        cmd_zoff  = 3'(zo);
        @(posedge clk);
        if (!wide) begin
            for (int j = 0; j < 16; j++) begin
                int c;
                c = (zo % 4) + 4 * j;
                for (int i = 0; i < 16; i++)
                    zm[c][32*i +: 32] = zm[c][32*i +: 32] + xm[xs][32*i +: 32] * ym[ys][32*j +: 32];
            end
        end else begin
            for (int j = 0; j < 8; j++) begin
                int c;
                c = zo + 8 * j;
                for (int i = 0; i < 8; i++)
                    zm[c][64*i +: 64] = zm[c][64*i +: 64] + xm[xs][64*i +: 64] * ym[ys][64*j +: 64];
            end
        end
    endtask

    // Store a line and compare it one cycle after acceptance.
    task automatic store_chk(input string req, input logic [1:0] bank, input int idx,
                             input logic [LW-1:0] exp);
        issue(3'd3, bank, idx, '0);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({req, " rsp_valid"}, LW'(rsp_valid), LW'(1));
        chk(req, rsp_data, exp);
    endtask

    task automatic check_all_z(input string req);
        for (int c = 0; c < 64; c++) store_chk(req, 2'd2, c, zm[c]);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin xm[k] = '0; ym[k] = '0; end
        for (int k = 0; k < 64; k++) zm[k] = '0;

        // R1: state while reset is held
        repeat (3) @(negedge clk);
        chk("R1 active", LW'(active), '0);
        chk("R1 err", LW'(err), '0);
        chk("R1 rsp_valid", LW'(rsp_valid), '0);
        chk("R1 cmd_ready", LW'(cmd_ready), LW'(1));
        rst_n = 1'b1;

        // R3: load while disabled is dropped and flagged
        issue(3'd2, 2'd0, 0, {16{32'hdead_beef}});
        idle();
        chk("R3 err set", LW'(err), LW'(1));
        chk("R3 stays idle", LW'(active), '0);
        issue(3'd3, 2'd2, 5, '0);
        idle();
        chk("R3 no response", LW'(rsp_valid), '0);

        // R2: start
        issue(3'd0, 2'd0, 0, '0);
        idle();
        chk("R2 active", LW'(active), LW'(1));
        chk("R3 err sticky", LW'(err), LW'(1));
        store_chk("R3 X0 untouched", 2'd0, 0, '0);
        store_chk("R1 Z5 zero", 2'd2, 5, '0);

        // R4: fill all banks, index aliasing for X and Y
        for (int k = 0; k < 8; k++) load(2'd0, (k % 2 == 1) ? k + 8 : k, next_line());
        for (int k = 0; k < 8; k++) load(2'd1, (k % 3 == 0) ? k + 16 : k, next_line());
        for (int k = 0; k < 64; k++) load(2'd2, k, next_line());
        for (int k = 0; k < 8; k++) store_chk("R4 X", 2'd0, k, xm[k]);
        for (int k = 0; k < 8; k++) store_chk("R4 Y", 2'd1, k, ym[k]);
        store_chk("R4 Z", 2'd2, 63, zm[63]);
        @(negedge clk);
        chk("R4 rsp_valid falls", LW'(rsp_valid), '0);

        // R5, R8: all X/Y pairs back-to-back, 32-bit lanes, offsets 0..7
        for (int xs = 0; xs < 8; xs++)
            for (int ys = 0; ys < 8; ys++)
                mac(1'b0, xs, ys, (xs + ys) % 8);
        idle();
        check_all_z("R5 narrow sweep");

        // R7: one narrow step; columns outside offset 2 must keep their value
        mac(1'b0, 3, 6, 2);
        idle();
        for (int c = 0; c < 64; c++)
            store_chk((c % 4 == 2) ? "R5 target" : "R7 untouched", 2'd2, c, zm[c]);
        for (int k = 0; k < 8; k++) store_chk("R7 X kept", 2'd0, k, xm[k]);
        for (int k = 0; k < 8; k++) store_chk("R7 Y kept", 2'd1, k, ym[k]);

        // R6, R8: all X/Y pairs back-to-back, 64-bit lanes
        for (int xs = 0; xs < 8; xs++)
            for (int ys = 0; ys < 8; ys++)
                mac(1'b1, xs, ys, (3 * xs + ys) % 8);
        idle();
        check_all_z("R6 wide sweep");

        // R8: load then compute on the very next cycle
        load(2'd2, 10, next_line());
        load(2'd0, 3, next_line());
        mac(1'b0, 3, 1, 2);
        mac(1'b1, 3, 2, 2);
        idle();
        store_chk("R8 forward Z10", 2'd2, 10, zm[10]);
        store_chk("R8 forward Z18", 2'd2, 18, zm[18]);
        store_chk("R8 forward Z14", 2'd2, 14, zm[14]);

        // R2: stop clears every bank
        issue(3'd1, 2'd0, 0, '0);
        idle();
        chk("R2 idle after stop", LW'(active), '0);
        issue(3'd3, 2'd0, 2, '0);
        idle();
        chk("R3 store while idle", LW'(rsp_valid), '0);
        issue(3'd0, 2'd0, 0, '0);
        idle();
        store_chk("R2 X cleared", 2'd0, 2, '0);
        store_chk("R2 Y cleared", 2'd1, 5, '0);
        store_chk("R2 Z cleared", 2'd2, 63, '0);
        store_chk("R2 Z10 cleared", 2'd2, 10, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule